// File: doc/BRIEF.md
# Decode-Stage Branch and Jump Resolver

This block sits at the decode stage of a five-stage in-order pipeline. It owns the fetch-to-decode register. It resolves equal-compare branches and absolute jumps while the instruction is still in decode. A taken branch or a jump therefore costs a single cycle: the one instruction fetched behind it is dropped.

The two compared operands come from the register file unless a newer value is in flight. A value produced by an arithmetic instruction two or three slots ahead is taken from the memory-stage or write-back-stage result bus. A value that cannot exist yet holds the branch in decode. Such values are an arithmetic result still in execute, or a load result not yet returned. The surrounding pipeline moves its producers forward each cycle. As a result, an arithmetic producer directly ahead costs one stall cycle. A load directly ahead costs two, and a load two slots ahead costs one.

Control pins are plain levels. `id_stall` tells the pipeline to hold the program counter and to insert a bubble into execute. `redirect` with `redirect_pc` tells fetch where to go next.

Top module: `id_branch_unit`

## Requirements
- R1: A branch's `redirect_pc` equals its `id_pc_plus4` plus the 16-bit field `id_instr[15:0]`, sign-extended and multiplied by four; a negative field gives a target below `id_pc_plus4`.
- R2: A valid decode instruction with `id_instr[31:26] == 4` whose two operands (registers `id_instr[25:21]` and `id_instr[20:16]`) are equal, and that is not stalled, raises `redirect`. On the next clock the decode slot is emptied (`id_valid` 0, `id_instr` 0) whatever fetch offered. Unequal operands raise no `redirect`, and the fetched instruction enters decode normally.
- R3: A valid decode instruction with `id_instr[31:26] == 2` raises `redirect` with `redirect_pc = {id_pc_plus4[31:28], id_instr[25:0], 2'b00}`. It never stalls, whatever is in flight.
- R4: An operand matching the memory-stage destination of a non-load write (`mem_we`=1, `mem_is_load`=0) uses `mem_val` instead of the register file, with no stall.
- R5: An operand matching the write-back destination uses `wb_val` with no stall. When the memory stage and the write-back stage both match, the memory stage wins.
- R6: An operand matching an execute-stage destination (`ex_we`=1) raises `id_stall` and suppresses `redirect`. Once that producer reaches the memory stage as a non-load, the branch resolves.
- R7: An operand matching a memory-stage load raises `id_stall`. A load first seen in execute and then in memory therefore stalls the branch for exactly two cycles.
- R8: Register 0 never matches a producer, and a producer with its write enable low never matches.
- R9: While `id_stall` is high, `redirect` is low, and on the next clock `id_instr`, `id_pc_plus4` and `id_valid` keep their values.
- R10: After reset and whenever decode holds no branch or jump (or `id_valid` is 0), both `id_stall` and `redirect` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_valid | input | 1 | Fetch offers an instruction |
| if_instr | input | 32 | Fetched instruction word |
| if_pc_plus4 | input | 32 | Address after the fetched instruction |
| rf_rs_val | input | 32 | Register file value of the first source |
| rf_rt_val | input | 32 | Register file value of the second source |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_rd | input | 5 | Execute-stage destination register |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_rd | input | 5 | Memory-stage destination register |
| mem_val | input | 32 | Memory-stage arithmetic result |
| wb_we | input | 1 | Write-back instruction writes a register |
| wb_rd | input | 5 | Write-back destination register |
| wb_val | input | 32 | Write-back value |
| id_valid | output | 1 | Decode slot holds a live instruction |
| id_instr | output | 32 | Instruction in decode |
| id_pc_plus4 | output | 32 | Address after the decode instruction |
| id_stall | output | 1 | Hold fetch and decode, bubble execute |
| redirect | output | 1 | Fetch must continue at redirect_pc |
| redirect_pc | output | 32 | Branch or jump target |

## Verification
The checker watches every cycle for the following properties. A stall never coincides with a redirect. A stall freezes the decode slot, and a redirect empties it on the next clock. A jump always redirects without stalling. An execute-stage match on a live branch always stalls. Targets stay word aligned, and an empty decode slot is quiet. Other behaviour depends on values and order, so only the directed scenarios can show it. This covers the arithmetic of the target for both signs and the choice of memory over write-back. It also covers the exact two-cycle stall as a load walks forward, and the fact that register 0 and disabled writers are never forwarded.

// File: rtl/id_branch_pkg.sv
package id_branch_pkg;
  localparam int XLEN     = 32;
  localparam int RIDX_W   = 5;
  localparam int OPC_W    = 6;
  localparam int DISP_W   = 16;
  localparam int JIDX_W   = 26;
  localparam int OPC_LSB  = XLEN - OPC_W;
  localparam int RS_LSB   = OPC_LSB - RIDX_W;
  localparam int RT_LSB   = RS_LSB - RIDX_W;
  localparam int PAGE_W   = XLEN - JIDX_W - 2;
  localparam int N_OPND   = 2;

  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'd4;
  localparam logic [OPC_W-1:0] OPC_JUMP = 6'd2;

  typedef struct packed {
    logic              we;
    logic [RIDX_W-1:0] rd;
    logic [XLEN-1:0]   val;
  } wr_port_t;

  function automatic logic reg_hit(input logic we, input logic [RIDX_W-1:0] rd,
                                   input logic [RIDX_W-1:0] src);
    return we && (rd != '0) && (rd == src);
  endfunction
endpackage

// File: rtl/id_slot_reg.sv
module id_slot_reg
  import id_branch_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            squash,
  input  logic            in_valid,
  input  logic [XLEN-1:0] in_instr,
  input  logic [XLEN-1:0] in_pc4,
  output logic            q_valid,
  output logic [XLEN-1:0] q_instr,
  output logic [XLEN-1:0] q_pc4
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_instr <= '0;
      q_pc4   <= '0;
    end else if (hold) begin
      q_valid <= q_valid;
    end else if (squash) begin
      q_valid <= 1'b0;
      q_instr <= '0;
      q_pc4   <= in_pc4;
    end else begin
      q_valid <= in_valid;
      q_instr <= in_instr;
      q_pc4   <= in_pc4;
    end
  end
endmodule

// File: rtl/id_operand_sel.sv
module id_operand_sel
  import id_branch_pkg::*;
(
  input  logic [RIDX_W-1:0] src,
  input  logic [XLEN-1:0]   rf_val,
  input  logic              ex_we,
  input  logic [RIDX_W-1:0] ex_rd,
  input  wr_port_t          mem_p,
  input  logic              mem_is_load,
  input  wr_port_t          wb_p,
  output logic [XLEN-1:0]   val,
  output logic              not_ready
);
  logic ex_hit, mem_hit, wb_hit;

  always_comb begin
    ex_hit    = reg_hit(ex_we, ex_rd, src);
    mem_hit   = reg_hit(mem_p.we, mem_p.rd, src);
    wb_hit    = reg_hit(wb_p.we, wb_p.rd, src);
    not_ready = ex_hit || (mem_hit && mem_is_load);
    if (mem_hit)     val = mem_p.val;
    else if (wb_hit) val = wb_p.val;
    else             val = rf_val;
  end
endmodule

// File: rtl/id_target_gen.sv
module id_target_gen
  import id_branch_pkg::*;
(
  input  logic [XLEN-1:0]   pc4,
  input  logic [JIDX_W-1:0] field,
  output logic [XLEN-1:0]   br_tgt,
  output logic [XLEN-1:0]   j_tgt
);
  localparam int SEXT_W = XLEN - DISP_W - 2;
  logic [DISP_W-1:0] disp;

  always_comb begin
    disp   = field[DISP_W-1:0];
    br_tgt = pc4 + {{SEXT_W{disp[DISP_W-1]}}, disp, 2'b00};
    j_tgt  = {pc4[XLEN-1 -: PAGE_W], field, 2'b00};
  end
endmodule

// File: rtl/id_branch_unit.sv
module id_branch_unit
  import id_branch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_valid,
  input  logic [XLEN-1:0]   if_instr,
  input  logic [XLEN-1:0]   if_pc_plus4,
  input  logic [XLEN-1:0]   rf_rs_val,
  input  logic [XLEN-1:0]   rf_rt_val,
  input  logic              ex_we,
  input  logic              ex_is_load,
  input  logic [RIDX_W-1:0] ex_rd,
  input  logic              mem_we,
  input  logic              mem_is_load,
  input  logic [RIDX_W-1:0] mem_rd,
  input  logic [XLEN-1:0]   mem_val,
  input  logic              wb_we,
  input  logic [RIDX_W-1:0] wb_rd,
  input  logic [XLEN-1:0]   wb_val,
  output logic              id_valid,
  output logic [XLEN-1:0]   id_instr,
  output logic [XLEN-1:0]   id_pc_plus4,
  output logic              id_stall,
  output logic              redirect,
  output logic [XLEN-1:0]   redirect_pc
);
  wr_port_t          mem_p, wb_p;
  logic [OPC_W-1:0]  opc;
  logic              is_br, is_jmp, cmp_eq, any_wait;
  logic [RIDX_W-1:0] src   [N_OPND];
  logic [XLEN-1:0]   rfv   [N_OPND];
  logic [XLEN-1:0]   opnd  [N_OPND];
  logic [N_OPND-1:0] wait_v;
  logic [XLEN-1:0]   br_tgt, j_tgt;

  // The execute-stage load flag needs no use here: any execute match stalls,
  // and the producer's type only matters once it reaches the memory stage.
  logic unused_ex_load;
  assign unused_ex_load = ex_is_load;

  assign mem_p = '{we: mem_we, rd: mem_rd, val: mem_val};
  assign wb_p  = '{we: wb_we,  rd: wb_rd,  val: wb_val};

  assign opc    = id_instr[XLEN-1 -: OPC_W];
  assign src[0] = id_instr[RS_LSB +: RIDX_W];
  assign src[1] = id_instr[RT_LSB +: RIDX_W];
  assign rfv[0] = rf_rs_val;
  assign rfv[1] = rf_rt_val;

  generate
    for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
      id_operand_sel u_sel (
        .src        (src[k]),
        .rf_val     (rfv[k]),
        .ex_we      (ex_we),
        .ex_rd      (ex_rd),
        .mem_p      (mem_p),
        .mem_is_load(mem_is_load),
        .wb_p       (wb_p),
        .val        (opnd[k]),
        .not_ready  (wait_v[k])
      );
    end
  endgenerate

  id_target_gen u_tgt (
    .pc4   (id_pc_plus4),
    .field (id_instr[JIDX_W-1:0]),
    .br_tgt(br_tgt),
    .j_tgt (j_tgt)
  );

  always_comb begin
    is_br       = id_valid && (opc == OPC_BEQ);
    is_jmp      = id_valid && (opc == OPC_JUMP);
    any_wait    = |wait_v;
    cmp_eq      = (opnd[0] == opnd[1]);
    id_stall    = is_br && any_wait;
    redirect    = is_jmp || (is_br && !any_wait && cmp_eq);
    redirect_pc = is_jmp ? j_tgt : br_tgt;
  end

  id_slot_reg u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (id_stall),
    .squash  (redirect),
    .in_valid(if_valid),
    .in_instr(if_instr),
    .in_pc4  (if_pc_plus4),
    .q_valid (id_valid),
    .q_instr (id_instr),
    .q_pc4   (id_pc_plus4)
  );
endmodule

// File: rtl/id_branch_chk.sv
module id_branch_chk
  import id_branch_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              id_valid,
  input logic [XLEN-1:0]   id_instr,
  input logic              id_stall,
  input logic              redirect,
  input logic [XLEN-1:0]   redirect_pc,
  input logic              ex_we,
  input logic [RIDX_W-1:0] ex_rd
);
  logic [OPC_W-1:0]  c_opc;
  logic [RIDX_W-1:0] c_rs, c_rt;
  assign c_opc = id_instr[XLEN-1 -: OPC_W];
  assign c_rs  = id_instr[RS_LSB +: RIDX_W];
  assign c_rt  = id_instr[RT_LSB +: RIDX_W];

  assert_stall_no_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    id_stall |-> !redirect);

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    id_stall |=> (id_valid && id_instr == $past(id_instr)));

  assert_squash_after_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !id_valid);

  assert_jump_redirects_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && c_opc == OPC_JUMP) |-> (redirect && !id_stall));

  assert_ex_match_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && c_opc == OPC_BEQ && ex_we && ex_rd != '0 &&
     (ex_rd == c_rs || ex_rd == c_rt)) |-> id_stall);

  assert_target_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (redirect_pc[1:0] == 2'b00));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> (!id_stall && !redirect));
endmodule

bind id_branch_unit id_branch_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .id_valid   (id_valid),
  .id_instr   (id_instr),
  .id_stall   (id_stall),
  .redirect   (redirect),
  .redirect_pc(redirect_pc),
  .ex_we      (ex_we),
  .ex_rd      (ex_rd)
);

// File: tb/tb_id_branch_unit.sv
module tb_id_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        if_valid = 1'b0;
  logic [31:0] if_instr = '0, if_pc_plus4 = '0;
  logic [31:0] rf_rs_val = '0, rf_rt_val = '0;
  logic        ex_we = 1'b0, ex_is_load = 1'b0;
  logic [4:0]  ex_rd = '0;
  logic        mem_we = 1'b0, mem_is_load = 1'b0;
  logic [4:0]  mem_rd = '0;
  logic [31:0] mem_val = '0;
  logic        wb_we = 1'b0;
  logic [4:0]  wb_rd = '0;
  logic [31:0] wb_val = '0;
  logic        id_valid, id_stall, redirect;
  logic [31:0] id_instr, id_pc_plus4, redirect_pc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  id_branch_unit dut (.*);

  function automatic logic [31:0] beq(input logic [4:0] a, input logic [4:0] b,
                                      input logic [15:0] d);
    return {6'd4, a, b, d};
  endfunction

  function automatic logic [31:0] jmp(input logic [25:0] f);
    return {6'd2, f};
  endfunction

  function automatic logic [31:0] exp_btgt(input logic [31:0] pc4, input logic [15:0] d);
    return pc4 + {{14{d[15]}}, d, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clr_prod();
    ex_we = 0; ex_is_load = 0; ex_rd = 0;
    mem_we = 0; mem_is_load = 0; mem_rd = 0; mem_val = 0;
    wb_we = 0; wb_rd = 0; wb_val = 0;
    rf_rs_val = 0; rf_rt_val = 0;
  endtask

  task automatic load_id(input logic [31:0] ins, input logic [31:0] pc4);
    @(negedge clk);
    clr_prod();
    if_valid = 0;
    @(negedge clk);
    if_valid = 1; if_instr = ins; if_pc_plus4 = pc4;
    @(negedge clk);
    if_valid = 0; if_instr = 0; if_pc_plus4 = 0;
  endtask

  task automatic t_reset();
    #1;
    chk(id_valid == 0, "R10", "valid in reset", 32'(id_valid), 0);
    chk(id_stall == 0 && redirect == 0, "R10", "quiet in reset", 32'({id_stall, redirect}), 0);
  endtask

  task automatic t_taken();
    load_id(beq(5'd3, 5'd4, 16'd5), 32'h0000_1000);
    rf_rs_val = 32'h55; rf_rt_val = 32'h55;
    #1;
    chk(redirect == 1 && id_stall == 0, "R2", "taken redirect", 32'(redirect), 1);
    chk(redirect_pc == exp_btgt(32'h1000, 16'd5), "R1", "forward target", redirect_pc, 32'h1014);
    if_valid = 1; if_instr = 32'hDEAD_BEEF; if_pc_plus4 = 32'h1008;
    @(negedge clk);
    if_valid = 0;
    #1;
    chk(id_valid == 0 && id_instr == 0, "R2", "wrong-path squashed", id_instr, 0);
    load_id(beq(5'd3, 5'd4, 16'hFFFE), 32'h0000_2000);
    rf_rs_val = 32'h7; rf_rt_val = 32'h7;
    #1;
    chk(redirect_pc == 32'h0000_1FF8, "R1", "backward target", redirect_pc, 32'h1FF8);
  endtask

  task automatic t_not_taken();
    load_id(beq(5'd5, 5'd6, 16'd9), 32'h0000_3000);
    rf_rs_val = 1; rf_rt_val = 2;
    #1;
    chk(redirect == 0 && id_stall == 0, "R2", "not taken", 32'({redirect, id_stall}), 0);
    if_valid = 1; if_instr = 32'h1234_5678; if_pc_plus4 = 32'h3004;
    @(negedge clk);
    if_valid = 0;
    #1;
    chk(id_valid == 1 && id_instr == 32'h1234_5678, "R2", "fall-through enters", id_instr, 32'h1234_5678);
  endtask

  task automatic t_jump();
    load_id(jmp(26'h123_4567), 32'hA000_0010);
    ex_we = 1; ex_is_load = 1; ex_rd = 5'h09;
    mem_we = 1; mem_is_load = 1; mem_rd = 5'h1A;
    #1;
    chk(id_stall == 0, "R3", "jump never stalls", 32'(id_stall), 0);
    chk(redirect == 1 && redirect_pc == {4'hA, 26'h123_4567, 2'b00}, "R3", "jump target",
        redirect_pc, {4'hA, 26'h123_4567, 2'b00});
  endtask

  task automatic t_fwd_mem();
    load_id(beq(5'd7, 5'd8, 16'd3), 32'h0000_4000);
    rf_rs_val = 1; rf_rt_val = 9;
    mem_we = 1; mem_rd = 7; mem_val = 9;
    #1;
    chk(redirect == 1 && id_stall == 0, "R4", "memory-stage forward", 32'({redirect, id_stall}), 32'b10);
  endtask

  task automatic t_fwd_wb();
    load_id(beq(5'd9, 5'd10, 16'd4), 32'h0000_4800);
    rf_rs_val = 5; rf_rt_val = 6;
    wb_we = 1; wb_rd = 10; wb_val = 5;
    #1;
    chk(redirect == 1 && id_stall == 0, "R5", "write-back forward", 32'({redirect, id_stall}), 32'b10);
    wb_rd = 9; wb_val = 7; mem_we = 1; mem_rd = 9; mem_val = 6;
    #1;
    chk(redirect == 1, "R5", "memory beats write-back", 32'(redirect), 1);
    mem_val = 7; wb_val = 6;
    #1;
    chk(redirect == 0, "R5", "memory beats write-back (unequal)", 32'(redirect), 0);
  endtask

  task automatic t_ex_alu();
    load_id(beq(5'd11, 5'd12, 16'd2), 32'h0000_5000);
    rf_rs_val = 3; rf_rt_val = 3;
    ex_we = 1; ex_rd = 12;
    #1;
    chk(id_stall == 1, "R6", "execute producer stalls", 32'(id_stall), 1);
    chk(redirect == 0, "R9", "no redirect while stalled", 32'(redirect), 0);
    if_valid = 1; if_instr = 32'h0000_CAFE;
    @(negedge clk);
    if_valid = 0;
    ex_we = 0; ex_rd = 0; mem_we = 1; mem_rd = 12; mem_val = 3;
    #1;
    chk(id_valid == 1 && id_instr == beq(5'd11, 5'd12, 16'd2), "R9", "decode held",
        id_instr, beq(5'd11, 5'd12, 16'd2));
    chk(id_stall == 0 && redirect == 1, "R6", "resolves from memory stage",
        32'({id_stall, redirect}), 32'b01);
  endtask

  task automatic t_load_two();
    int stalls = 0;
    load_id(beq(5'd13, 5'd14, 16'd1), 32'h0000_6000);
    rf_rs_val = 4; rf_rt_val = 4;
    ex_we = 1; ex_is_load = 1; ex_rd = 13;
    #1;
    if (id_stall) stalls++;
    @(negedge clk);
    ex_we = 0; ex_is_load = 0; ex_rd = 0;
    mem_we = 1; mem_is_load = 1; mem_rd = 13; mem_val = 32'hBAD;
    #1;
    chk(id_stall == 1, "R7", "load in memory stalls", 32'(id_stall), 1);
    if (id_stall) stalls++;
    @(negedge clk);
    mem_we = 0; mem_is_load = 0; mem_rd = 0;
    wb_we = 1; wb_rd = 13; wb_val = 4;
    #1;
    if (id_stall) stalls++;
    chk(stalls == 2, "R7", "load directly ahead stall count", 32'(stalls), 2);
    chk(redirect == 1, "R7", "resolves after load", 32'(redirect), 1);
  endtask

  task automatic t_zero();
    load_id(beq(5'd0, 5'd1, 16'd8), 32'h0000_7000);
    ex_we = 1; ex_is_load = 1; ex_rd = 0;
    mem_we = 1; mem_rd = 0; mem_val = 32'h55;
    #1;
    chk(id_stall == 0 && redirect == 1, "R8", "register 0 never matches",
        32'({id_stall, redirect}), 32'b01);
    load_id(beq(5'd15, 5'd16, 16'd8), 32'h0000_7400);
    rf_rs_val = 8; rf_rt_val = 8;
    ex_we = 0; ex_rd = 15; mem_we = 0; mem_rd = 15; mem_val = 99;
    #1;
    chk(id_stall == 0 && redirect == 1, "R8", "disabled writer ignored",
        32'({id_stall, redirect}), 32'b01);
  endtask

  task automatic t_idle();
    load_id({6'd0, 5'd17, 5'd17, 16'h0820}, 32'h0000_8000);
    ex_we = 1; ex_is_load = 1; ex_rd = 17;
    #1;
    chk(id_stall == 0 && redirect == 0, "R10", "non-branch is quiet",
        32'({id_stall, redirect}), 0);
  endtask

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_taken();
    t_not_taken();
    t_jump();
    t_fwd_mem();
    t_fwd_wb();
    t_ex_alu();
    t_load_two();
    t_zero();
    t_idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule